// File: doc/BRIEF.md
# Error-Tagged Serial Receive Channel

This block is one asynchronous serial receive channel. It oversamples the incoming line sixteen times per bit, using a clock divider that the host programs. Each character it recovers is stored in a deep receive queue. Every queue entry holds the data byte together with four flags for that character: parity error, overrun, framing error and break. A host sees the character at the head of the queue and the number of entries held. It removes entries one at a time with a pop strobe.

The character format is set on static inputs: data width of 5 to 8 bits, one or two stop bits, and parity. Parity can be off, even, odd, or forced to a fixed level (stick mode). A data-available flag is raised when the queue holds at least a chosen number of entries and the flag is enabled. The threshold is picked from a small fixed set. Two further controls stop reception and empty the queue.

The divisor input holds the divide ratio minus one. With a 44.2368 MHz clock, a divisor input of 287 (ratio 288) gives 9600 baud.

Top module: `serial_rx_tagged`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `rx_count` is 0 and `rx_avail` is 0. The queue holds up to 512 entries, and `rx_count` always equals the number held. A pop removes the head entry. A pop while the queue is empty has no effect.
- R2: Each entry on `rd_entry` is laid out as follows: bits 7:0 hold the character, bit 8 is the parity-error flag, bit 9 the overrun flag, bit 10 the framing-error flag and bit 11 the break flag. Entries leave the queue in arrival order.
- R3: One bit lasts 16 × (`cfg_div_m1` + 1) clock cycles, so a value of 0 divides by one. Characters sent at that rate are received correctly for more than one divisor value.
- R4: `cfg_data_sel` selects the data width: 0 → 5 bits, 1 → 6, 2 → 7, 3 → 8. Bits arrive least significant first. Character bits above the selected width read as 0.
- R5: When `cfg_two_stop` is 1, both stop positions are checked. A low level at the second stop position sets the framing flag.
- R6: When `cfg_par_en` is 1, a parity bit follows the data and a mismatch sets the parity flag. `cfg_par_even` = 1 selects even parity and 0 selects odd. With `cfg_par_stick` = 1 the expected bit is fixed: 0 when `cfg_par_even` = 1, and 1 when it is 0.
- R7: A low first stop bit on a character that has at least one high data or parity bit sets the framing flag, with the character kept.
- R8: A character whose data, parity and first stop positions are all low produces one entry with only the break flag set and a zero character. No further entry is produced until the line has returned high.
- R9: A character that completes while the queue holds 512 entries is discarded. The next entry that is accepted carries the overrun flag.
- R10: `rx_avail` is 1 exactly when `cfg_irq_en` is 1 and `rx_count` is at least the selected level. `cfg_thr_sel` selects the level: 1 → 1 entry, 2 → 256, 3 → 448. A value of 0 keeps `rx_avail` at 0.
- R11: While `flush` is 1, the queue is emptied, characters that complete are discarded, and a pending overrun mark is cleared.
- R12: While `rx_en` is 0, nothing is received: a complete character on the line adds no entry.
- R13: A low pulse that does not last until the middle of a start bit is ignored and adds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| rx_en | input | 1 | Receive enable |
| cfg_div_m1 | input | DIV_W | Divide ratio minus one |
| cfg_data_sel | input | 2 | Data width code |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_par_en | input | 1 | Parity present |
| cfg_par_even | input | 1 | 1 = even, 0 = odd parity |
| cfg_par_stick | input | 1 | Fixed-level parity |
| cfg_thr_sel | input | 2 | Data-available threshold code |
| cfg_irq_en | input | 1 | Data-available enable |
| flush | input | 1 | Empty the queue while set |
| pop | input | 1 | Remove head entry |
| rd_entry | output | 12 | Head entry with flags |
| rx_count | output | clog2(FIFO_DEPTH+1) | Entries held |
| rx_avail | output | 1 | Threshold reached and enabled |

## Verification
Faults inside the block show up at the ports within one character time.

- A wrong bit counter or sample phase gives a wrong character or a wrong flag at the head of the queue. This appears in the cycle after the stop-bit sample.
- A queue pointer or count error shows as a wrong `rx_count` in the next cycle.
- A wrong head entry shows up at the next pop.
- A lost overrun mark shows up only on the first entry accepted after the queue was full, so that case is driven to the 512-entry limit and read back through the queue.

// File: rtl/srx_pkg.sv
// Shared types for the serial receive channel.
// Assumes the queue entry layout is fixed by the host's field decoding.
package srx_pkg;
    localparam int ENTRY_W = 12;

    // Entry layout, MSB first: break, framing, overrun, parity, character.
    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       ovr;
        logic       perr;
        logic [7:0] data;
    } srx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_HOLD
    } srx_state_t;
endpackage

// File: rtl/srx_baud_tick.sv
// Oversampling tick generator: one tick every (div_m1 + 1) clocks.
// Assumes div_m1 is static while a character is being received.
module srx_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Divide counter; the >= compare recovers if div_m1 shrinks.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div_m1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/srx_frame.sv
// Character framer: finds the start bit, samples each bit in the middle of
// its 16-tick cell, and emits one tagged entry per character.
// Assumes rxd is already synchronised and the format inputs are static.
module srx_frame
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] data_sel,
    input  logic       two_stop,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       push,
    output srx_entry_t entry
);
    localparam logic [3:0] MID_START = 4'd7;
    localparam logic [3:0] MID_CELL  = 4'd15;

    srx_state_t state;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] shreg;
    logic       seen_one;
    logic       par_bit;
    logic       stop_bad;
    logic [2:0] last_idx;
    logic       exp_par;
    logic       perr;
    logic       cell_mid;

    // Index of the last data bit for the selected width.
    assign last_idx = {1'b0, data_sel} + 3'd4;
    // Expected parity level for the format in force.
    assign exp_par  = par_stick ? ~par_even : ((^shreg) ^ ~par_even);
    assign perr     = par_en && (par_bit != exp_par);
    assign cell_mid = tick && (tcnt == MID_CELL);

    // Frame state machine and entry assembly.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state    <= S_IDLE;
            push     <= 1'b0;
            entry    <= '0;
            tcnt     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            seen_one <= 1'b0;
            par_bit  <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            push <= 1'b0;
            case (state)
                S_IDLE: if (tick && !rxd) begin
                    state <= S_START;
                    tcnt  <= '0;
                end
                S_START: if (tick) begin
                    if (tcnt == MID_START) begin
                        if (!rxd) begin
                            state    <= S_DATA;
                            tcnt     <= '0;
                            bidx     <= '0;
                            shreg    <= '0;
                            seen_one <= 1'b0;
                            par_bit  <= 1'b0;
                            stop_bad <= 1'b0;
                        end else begin
                            state <= S_IDLE;
                        end
                    end else begin
                        tcnt <= tcnt + 4'd1;
                    end
                end
                S_DATA: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (cell_mid) begin
                        shreg[bidx] <= rxd;
                        seen_one    <= seen_one | rxd;
                        if (bidx == last_idx) state <= par_en ? S_PAR : S_STOP1;
                        else                  bidx  <= bidx + 3'd1;
                    end
                end
                S_PAR: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (cell_mid) begin
                        par_bit  <= rxd;
                        seen_one <= seen_one | rxd;
                        state    <= S_STOP1;
                    end
                end
                S_STOP1: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (cell_mid) begin
                        if (!rxd && !seen_one) begin
                            push  <= 1'b1;
                            entry <= '{brk: 1'b1, frm: 1'b0, ovr: 1'b0, perr: 1'b0, data: 8'h00};
                            state <= S_HOLD;
                        end else if (two_stop) begin
                            stop_bad <= ~rxd;
                            state    <= S_STOP2;
                        end else begin
                            push  <= 1'b1;
                            entry <= '{brk: 1'b0, frm: ~rxd, ovr: 1'b0, perr: perr, data: shreg};
                            state <= rxd ? S_IDLE : S_HOLD;
                        end
                    end
                end
                S_STOP2: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (cell_mid) begin
                        push  <= 1'b1;
                        entry <= '{brk: 1'b0, frm: stop_bad | ~rxd, ovr: 1'b0, perr: perr, data: shreg};
                        state <= rxd ? S_IDLE : S_HOLD;
                    end
                end
                S_HOLD: if (rxd) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srx_store.sv
// Receive queue with per-entry flags and overrun marking.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module srx_store
    import srx_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  srx_entry_t                   wr_entry,
    input  logic                         pop,
    input  logic                         flush,
    output srx_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [AW-1:0]      wr_ptr, rd_ptr;
    logic               ovr_pend;
    logic               full, do_pop, accept, drop;
    srx_entry_t         wdata;

    assign full   = (count == CW'(DEPTH));
    assign do_pop = pop && (count != '0);
    assign accept = push && !flush && (!full || do_pop);
    assign drop   = push && !flush && full && !do_pop;
    assign head   = mem[rd_ptr];

    // Attach a pending overrun mark to the entry being written.
    always_comb begin
        wdata     = wr_entry;
        wdata.ovr = ovr_pend;
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wdata;
    end

    // Pointers, occupancy and overrun bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            case ({accept, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (drop)        ovr_pend <= 1'b1;
            else if (accept) ovr_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_tagged.sv
// Top of the serial receive channel: line synchroniser, tick generator,
// framer, tagged queue and the threshold flag.
// Assumes all cfg_* inputs change only while the line is idle.
module serial_rx_tagged
    import srx_pkg::*;
#(
    parameter int FIFO_DEPTH = 512,
    parameter int DIV_W      = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rxd_in,
    input  logic                            rx_en,
    input  logic [DIV_W-1:0]                cfg_div_m1,
    input  logic [1:0]                      cfg_data_sel,
    input  logic                            cfg_two_stop,
    input  logic                            cfg_par_en,
    input  logic                            cfg_par_even,
    input  logic                            cfg_par_stick,
    input  logic [1:0]                      cfg_thr_sel,
    input  logic                            cfg_irq_en,
    input  logic                            flush,
    input  logic                            pop,
    output logic [11:0]                     rd_entry,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_count,
    output logic                            rx_avail
);
    localparam int CW     = $clog2(FIFO_DEPTH + 1);
    localparam int LVL_HI = FIFO_DEPTH - FIFO_DEPTH / 8;
    localparam int LVL_MD = FIFO_DEPTH / 2;

    logic [1:0]  sync;
    logic        tick;
    logic        fr_push;
    srx_entry_t  fr_entry;
    srx_entry_t  head;
    logic [CW-1:0] lvl;

    // Two-flop synchroniser, reset to the idle (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd_in};
    end

    srx_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .div_m1(cfg_div_m1), .tick(tick)
    );

    srx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rxd(sync[1]),
        .data_sel(cfg_data_sel), .two_stop(cfg_two_stop), .par_en(cfg_par_en),
        .par_even(cfg_par_even), .par_stick(cfg_par_stick),
        .push(fr_push), .entry(fr_entry)
    );

    srx_store #(.DEPTH(FIFO_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(fr_push), .wr_entry(fr_entry),
        .pop(pop), .flush(flush), .head(head), .count(rx_count)
    );

    // Threshold level for the selected code.
    always_comb begin
        case (cfg_thr_sel)
            2'd1:    lvl = CW'(1);
            2'd2:    lvl = CW'(LVL_MD);
            2'd3:    lvl = CW'(LVL_HI);
            default: lvl = '0;
        endcase
    end

    assign rx_avail = cfg_irq_en && (cfg_thr_sel != 2'd0) && (rx_count >= lvl);
    assign rd_entry = head;
endmodule

// File: rtl/srx_checker.sv
// Property checker for serial_rx_tagged, attached by bind.
module srx_checker
    import srx_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rx_en,
    input logic                         flush,
    input logic [1:0]                   thr_sel,
    input logic                         fr_push,
    input srx_entry_t                   fr_entry,
    input logic [$clog2(DEPTH+1)-1:0]   count,
    input logic                         rx_avail
);
    localparam int CW = $clog2(DEPTH + 1);

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(flush) |-> (count == $past(count) || count == $past(count) + CW'(1)
                           || count + CW'(1) == $past(count)));

    p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);

    p_avail_needs_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail |-> count != '0);

    p_zero_thr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        thr_sel == 2'd0 |-> !rx_avail);

    p_disabled_no_push_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !fr_push);

    p_break_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_push && fr_entry.brk) |-> (fr_entry.data == 8'h00 && !fr_entry.frm && !fr_entry.perr));
endmodule

bind serial_rx_tagged srx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush), .thr_sel(cfg_thr_sel),
    .fr_push(fr_push), .fr_entry(fr_entry), .count(rx_count), .rx_avail(rx_avail)
);

// File: tb/serial_rx_tagged_test.sv
module serial_rx_tagged_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd_in = 1'b1;
    logic        rx_en = 1'b0;
    logic [15:0] cfg_div_m1 = 16'd0;
    logic [1:0]  cfg_data_sel = 2'd3;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_even = 1'b1;
    logic        cfg_par_stick = 1'b0;
    logic [1:0]  cfg_thr_sel = 2'd1;
    logic        cfg_irq_en = 1'b1;
    logic        flush = 1'b0;
    logic        pop = 1'b0;
    logic [11:0] rd_entry;
    logic [9:0]  rx_count;
    logic        rx_avail;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit inflight = 1'b0;
    bit done = 1'b0;
    bit pend = 1'b0;
    logic [11:0] q[$];

    always #10 clk = ~clk;

    serial_rx_tagged uut (
        .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .rx_en(rx_en),
        .cfg_div_m1(cfg_div_m1), .cfg_data_sel(cfg_data_sel),
        .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
        .cfg_thr_sel(cfg_thr_sel), .cfg_irq_en(cfg_irq_en),
        .flush(flush), .pop(pop), .rd_entry(rd_entry),
        .rx_count(rx_count), .rx_avail(rx_avail)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_avail();
        int lvl;
        case (cfg_thr_sel)
            2'd1: lvl = 1;
            2'd2: lvl = 256;
            2'd3: lvl = 448;
            default: lvl = 0;
        endcase
        return cfg_irq_en && lvl != 0 && q.size() >= lvl;
    endfunction

    // Reference comparison on every clock while no character is in flight.
    always @(negedge clk) begin
        if (mon_on && !inflight) begin
            check(int'(rx_count) == q.size(), "R1 count", int'(rx_count), q.size());
            check(rx_avail == exp_avail(), "R10 avail", int'(rx_avail), int'(exp_avail()));
            if (q.size() > 0)
                check(rd_entry == q[0], "R2 head", int'(rd_entry), int'(q[0]));
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic v, input int n);
        rxd_in = v;
        repeat (n) step();
    endtask

    task automatic model_push(input logic [11:0] e);
        if (q.size() == 512) pend = 1'b1;
        else begin
            e[9] = pend;
            q.push_back(e);
            pend = 1'b0;
        end
    endtask

    task automatic send_char(input logic [7:0] d, input bit bad_par, input bit bad_s1, input bit bad_s2);
        int nb;
        int bc;
        logic [7:0] dm;
        logic pb;
        bit brk, frm, perr;
        nb = int'(cfg_data_sel) + 5;
        bc = (int'(cfg_div_m1) + 1) * 16;
        dm = d & 8'((9'h1 << nb) - 9'h1);
        pb = cfg_par_stick ? !cfg_par_even : ((^dm) ^ !cfg_par_even);
        pb = pb ^ bad_par;
        inflight = 1'b1;
        drive(1'b0, bc);
        for (int i = 0; i < nb; i++) drive(dm[i], bc);
        if (cfg_par_en) drive(pb, bc);
        drive(!bad_s1, bc);
        if (cfg_two_stop) drive(!bad_s2, bc);
        drive(1'b1, 3);
        brk  = bad_s1 && dm == 8'h00 && !(cfg_par_en && pb);
        frm  = !brk && (bad_s1 || (cfg_two_stop && bad_s2));
        perr = !brk && cfg_par_en && bad_par;
        if (rx_en) model_push({brk, frm, 1'b0, perr, brk ? 8'h00 : dm});
        inflight = 1'b0;
    endtask

    task automatic pop_one();
        pop = 1'b1;
        step();
        pop = 1'b0;
        if (q.size() > 0) void'(q.pop_front());
    endtask

    task automatic do_flush();
        flush = 1'b1;
        step();
        q.delete();
        pend = 1'b0;
        flush = 1'b0;
    endtask

    task automatic head_is(input logic [11:0] e, input string tag);
        check(rd_entry == e, tag, int'(rd_entry), int'(e));
    endtask

    task automatic count_is(input int n, input string tag);
        check(int'(rx_count) == n, tag, int'(rx_count), n);
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        count_is(0, "R1 reset count");
        check(rx_avail == 1'b0, "R1 reset avail", int'(rx_avail), 0);
        mon_on = 1'b1;
        rx_en = 1'b1;
        repeat (4) step();

        // R2 R4: plain 8N1 character, LSB first
        send_char(8'hA5, 0, 0, 0);
        head_is(12'h0A5, "R2 R4 8-bit char");
        check(rx_avail == 1'b1, "R10 one entry", int'(rx_avail), 1);
        pop_one();
        pop_one();
        count_is(0, "R1 pop empty ignored");

        // R6: 7 bits, even parity good and bad
        cfg_data_sel = 2'd2; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        send_char(8'h41, 0, 0, 0);
        send_char(8'h41, 1, 0, 0);
        head_is(12'h041, "R6 even ok");
        pop_one();
        head_is(12'h141, "R6 even bad");
        pop_one();
        cfg_par_even = 1'b0;
        send_char(8'h41, 0, 0, 0);
        head_is(12'h041, "R6 odd ok");
        pop_one();
        cfg_par_even = 1'b1; cfg_par_stick = 1'b1;
        send_char(8'hFF, 0, 0, 0);
        send_char(8'hFF, 1, 0, 0);
        head_is(12'h07F, "R6 stick ok");
        pop_one();
        head_is(12'h17F, "R6 stick bad");
        pop_one();
        cfg_par_stick = 1'b0; cfg_par_en = 1'b0;

        // R4: 5-bit width masks upper bits
        cfg_data_sel = 2'd0;
        send_char(8'hFF, 0, 0, 0);
        head_is(12'h01F, "R4 5-bit");
        pop_one();

        // R5: 6 bits, two stops, bad second stop
        cfg_data_sel = 2'd1; cfg_two_stop = 1'b1;
        send_char(8'h2A, 0, 0, 0);
        send_char(8'h2A, 0, 0, 1);
        head_is(12'h02A, "R5 two stop ok");
        pop_one();
        head_is(12'h42A, "R5 second stop low");
        pop_one();
        cfg_two_stop = 1'b0; cfg_data_sel = 2'd3;

        // R7 framing, R8 break
        send_char(8'h55, 0, 1, 0);
        head_is(12'h455, "R7 framing");
        pop_one();
        send_char(8'h00, 0, 1, 0);
        count_is(1, "R8 single break entry");
        head_is(12'h800, "R8 break");
        pop_one();

        // R13: short glitch
        drive(1'b0, 3);
        drive(1'b1, 60);
        count_is(0, "R13 glitch ignored");

        // R12: disabled receiver
        rx_en = 1'b0;
        send_char(8'h33, 0, 0, 0);
        count_is(0, "R12 disabled");
        rx_en = 1'b1;
        repeat (4) step();

        // R3: divisor of three
        cfg_div_m1 = 16'd2;
        repeat (4) step();
        send_char(8'h3C, 0, 0, 0);
        head_is(12'h03C, "R3 divisor 3");
        pop_one();
        cfg_div_m1 = 16'd0;
        repeat (4) step();

        // R11: flush
        send_char(8'h11, 0, 0, 0);
        send_char(8'h22, 0, 0, 0);
        do_flush();
        count_is(0, "R11 flush");

        // R10 R9: fill to the limit
        cfg_thr_sel = 2'd3;
        for (int i = 0; i < 512; i++) begin
            send_char(8'(i), 0, 0, 0);
            if (i == 446) check(rx_avail == 1'b0, "R10 447 below 448", int'(rx_avail), 0);
            if (i == 447) check(rx_avail == 1'b1, "R10 448 reached", int'(rx_avail), 1);
        end
        cfg_thr_sel = 2'd2;
        step();
        check(rx_avail == 1'b1, "R10 half level", int'(rx_avail), 1);
        cfg_irq_en = 1'b0;
        step();
        check(rx_avail == 1'b0, "R10 disabled", int'(rx_avail), 0);
        cfg_irq_en = 1'b1; cfg_thr_sel = 2'd0;
        step();
        check(rx_avail == 1'b0, "R10 code zero", int'(rx_avail), 0);
        cfg_thr_sel = 2'd1;
        send_char(8'h99, 0, 0, 0);
        count_is(512, "R9 full drop");
        head_is(12'h000, "R9 head kept");
        pop_one();
        send_char(8'h77, 0, 0, 0);
        count_is(512, "R9 refill");
        repeat (510) pop_one();
        head_is(12'h0FF, "R9 last before");
        pop_one();
        head_is(12'h277, "R9 overrun mark");
        pop_one();
        count_is(0, "R1 drained");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule